// File: doc/BRIEF.md
# Serial Input Delay Calibrator

This block picks the sampling delay for a serial receive path. After a start pulse it applies each of four delay codes in turn (0, 1, 2, 3, standing for 0, 2, 4 and 6 ns of input delay). After each code has had a short, parameterised time to settle, it reads one fixed test register over a simple request/acknowledge read port. It records whether the returned word matches a known pattern.

Each result becomes one bit of a four-bit pass mask. Bit i stands for code i. Once the fourth read returns, a selection rule turns the mask into the delay code that stays applied. The rule takes a single passing code as it is. For two passing codes it prefers the one on the edge of the code range, and otherwise the smaller one. For three it takes the middle code, and for four the lower of the two middle codes. An empty mask, or a mask with a gap in it, is a calibration failure. The block then raises an error flag together with its done pulse, and it puts back the delay code that was active before the sweep began.

The delay line and the read transport sit outside the block. The block drives only the code, the read request and a constant test address.

Top module: `rx_delay_cal`

## Requirements
- R1: Out of reset, `dly_code` is 0 and `cal_done`, `cal_err` and `rd_req` are low.
- R2: A sweep applies codes 0, 1, 2, 3 in that order on `dly_code`. Each code is held for `SETTLE_CYC` cycles before its read request starts. `rd_addr` equals `TEST_ADDR`.
- R3: The mask bit for a code is set only when the returned `rd_data` equals `TEST_PATTERN` in every bit. A word that differs in a single bit counts as a fail.
- R4: A mask with exactly one bit set selects that code.
- R5: Two adjacent passing codes select as follows: mask 4'b0011 gives 0, 4'b0110 gives 1 and 4'b1100 gives 3.
- R6: Mask 4'b0111 gives 1, 4'b1110 gives 2 and 4'b1111 gives 1.
- R7: An empty mask, or one with a gap between passing codes, raises `cal_err` in the same cycle as `cal_done`. In that case `dly_code` returns to the value it had before the sweep. `cal_err` stays high until the next accepted start.
- R8: `cal_done` is a single-cycle pulse. It comes two cycles after the cycle in which the fourth read is acknowledged. `dly_code` takes its final value in the same cycle. `cal_err` is low after a passing sweep.
- R9: A `cal_start` pulse while a sweep is in progress has no effect.
- R10: `rd_req` stays high until `rd_ack` is seen, whatever the response latency. `rd_data` is taken in the cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Starts a calibration sweep when the block is idle |
| rd_req | output | 1 | Read request for the test register |
| rd_addr | output | ADDR_W | Address of the test register |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | DATA_W | Read response data |
| dly_code | output | 2 | Delay code applied to the input sampler |
| cal_done | output | 1 | One-cycle pulse at the end of a sweep |
| cal_err | output | 1 | Sweep failed; held until the next start |

## Verification
The bench goes through every passing mask of the selection rule, and the failing masks that are empty or have gaps. A wrong table entry shows up as a wrong final code. A selector that accepts gapped masks shows up as a missing error, or as a code that jumps to a value it never had. Failing sweeps follow a passing one, so the restored code is non-zero. A design that zeroes the code or keeps the last swept code on failure is therefore caught. Response latencies of zero, one and three cycles test the request hold, and a second start in the middle of a sweep must not restart the sequence. Failing reads differ from the pattern in one bit only, so a partial compare is also caught.

// File: rtl/rxdc_pkg.sv
package rxdc_pkg;
   localparam int unsigned NUM_CODES = 4;
   localparam int unsigned CODE_W    = $clog2(NUM_CODES);

   typedef logic [CODE_W-1:0]    code_t;
   typedef logic [NUM_CODES-1:0] mask_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_REQ,
      ST_FIN
   } seq_st_e;
endpackage

// File: rtl/rxdc_seq.sv
module rxdc_seq
   import rxdc_pkg::*;
#(
   parameter int unsigned SETTLE_CYC = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   input  logic  ack_i,
   output logic  req_o,
   output logic  take_o,
   output logic  clr_o,
   output logic  fin_o,
   output code_t idx_o
);
   localparam seq_st_e ST_AFTER = (SETTLE_CYC > 0) ? ST_SETTLE : ST_REQ;

   seq_st_e st_q, st_d;
   code_t   idx_q;
   logic    last;
   logic    settle_end;

   assign last = (idx_q == code_t'(NUM_CODES - 1));

   generate
      if (SETTLE_CYC > 0) begin : g_settle
         localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= CNT_W'(SETTLE_CYC - 1);
            else if (st_q != ST_SETTLE)  cnt_q <= CNT_W'(SETTLE_CYC - 1);
            else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
         end
         assign settle_end = (cnt_q == '0);
      end else begin : g_nosettle
         assign settle_end = 1'b1;
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (start_i)    st_d = ST_AFTER;
         ST_SETTLE: if (settle_end) st_d = ST_REQ;
         ST_REQ:    if (ack_i)      st_d = last ? ST_FIN : ST_AFTER;
         ST_FIN:                    st_d = ST_IDLE;
         default:                   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
      end else begin
         st_q <= st_d;
         if (clr_o)                idx_q <= '0;
         else if (take_o && !last) idx_q <= idx_q + 1'b1;
      end
   end

   assign req_o  = (st_q == ST_REQ);
   assign take_o = req_o && ack_i;
   assign clr_o  = (st_q == ST_IDLE) && start_i;
   assign fin_o  = (st_q == ST_FIN);
   assign idx_o  = idx_q;

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> req_o);
   assert_code_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> $stable(idx_o));
   assert_busy_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SETTLE && start_i) |=> (st_q != ST_IDLE));
endmodule

// File: rtl/rxdc_mask.sv
module rxdc_mask
   import rxdc_pkg::*;
#(
   parameter int unsigned       DATA_W       = 16,
   parameter logic [DATA_W-1:0] TEST_PATTERN = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              take_i,
   input  code_t             idx_i,
   input  logic [DATA_W-1:0] data_i,
   output mask_t             mask_o
);
   logic hit;
   assign hit = (data_i == TEST_PATTERN);

   generate
      for (genvar b = 0; b < NUM_CODES; b++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                bit_q <= 1'b0;
            else if (clr_i)                            bit_q <= 1'b0;
            else if (take_i && idx_i == code_t'(b))    bit_q <= hit;
         end
         assign mask_o[b] = bit_q;
      end
   endgenerate

   assert_mask_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (mask_o == '0));
endmodule

// File: rtl/rxdc_pick.sv
module rxdc_pick
   import rxdc_pkg::*;
(
   input  mask_t mask_i,
   output code_t code_o,
   output logic  ok_o
);
   always_comb begin
      ok_o   = 1'b1;
      code_o = '0;
      unique case (mask_i)
         4'b0001: code_o = 2'd0;
         4'b0010: code_o = 2'd1;
         4'b0100: code_o = 2'd2;
         4'b1000: code_o = 2'd3;
         4'b0011: code_o = 2'd0;
         4'b0110: code_o = 2'd1;
         4'b1100: code_o = 2'd3;
         4'b0111: code_o = 2'd1;
         4'b1110: code_o = 2'd2;
         4'b1111: code_o = 2'd1;
         default: ok_o   = 1'b0;
      endcase
   end
endmodule

// File: rtl/rx_delay_cal.sv
module rx_delay_cal
   import rxdc_pkg::*;
#(
   parameter int unsigned       DATA_W       = 16,
   parameter int unsigned       ADDR_W       = 16,
   parameter logic [ADDR_W-1:0] TEST_ADDR    = 16'h0040,
   parameter logic [DATA_W-1:0] TEST_PATTERN = 16'h5AA5,
   parameter int unsigned       SETTLE_CYC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic [1:0]        dly_code,
   output logic              cal_done,
   output logic              cal_err
);
   generate
      if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("rx_delay_cal: DATA_W and ADDR_W must be at least 1");
      end
      if (CODE_W != 2) begin : g_bad_codes
         $error("rx_delay_cal: selection rule needs exactly four codes");
      end
   endgenerate

   logic  take, clr, fin, ok;
   code_t idx, pick, dly_q, keep_q;
   mask_t mask;
   logic  done_q, err_q;

   rxdc_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (cal_start),
      .ack_i   (rd_ack),
      .req_o   (rd_req),
      .take_o  (take),
      .clr_o   (clr),
      .fin_o   (fin),
      .idx_o   (idx)
   );

   rxdc_mask #(.DATA_W(DATA_W), .TEST_PATTERN(TEST_PATTERN)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .take_i (take),
      .idx_i  (idx),
      .data_i (rd_data),
      .mask_o (mask)
   );

   rxdc_pick u_pick (
      .mask_i (mask),
      .code_o (pick),
      .ok_o   (ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_q  <= '0;
         keep_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= fin;
         if (clr) begin
            keep_q <= dly_q;
            dly_q  <= '0;
            err_q  <= 1'b0;
         end else if (take && idx != code_t'(NUM_CODES - 1)) begin
            dly_q <= idx + 1'b1;
         end else if (fin) begin
            dly_q <= ok ? pick : keep_q;
            err_q <= !ok;
         end
      end
   end

   assign rd_addr  = TEST_ADDR;
   assign dly_code = dly_q;
   assign cal_done = done_q;
   assign cal_err  = err_q;

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done);
   assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_err) |-> cal_done);
   assert_fail_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !ok) |=> (dly_code == $past(keep_q)));
   assert_pick_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && ok) |-> mask[pick]);
endmodule

// File: tb/rx_delay_cal_bench.sv
module rx_delay_cal_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int          SETTLE = 2;
   localparam logic [15:0] PAT    = 16'h5AA5;
   localparam logic [15:0] TADDR  = 16'h0040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cal_start = 1'b0;
   logic        rd_req;
   logic [15:0] rd_addr;
   logic        rd_ack = 1'b0;
   logic [15:0] rd_data = '0;
   logic [1:0]  dly_code;
   logic        cal_done;
   logic        cal_err;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   bit cmp_en = 0;
   logic [3:0] pass_map = '0;
   int lat_cfg = 0;
   int lat_cnt = 0;
   int last_good = 0;

   // behavioural reference state
   int ms = 0, mw = 0, mi = 0, md = 0, mk = 0;
   int mm = 0;
   bit mdone = 0, merr = 0;

   always #2.5 clk = ~clk;

   rx_delay_cal #(
      .DATA_W(16), .ADDR_W(16), .TEST_ADDR(TADDR),
      .TEST_PATTERN(PAT), .SETTLE_CYC(SETTLE)
   ) u_rx_delay_cal (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .dly_code(dly_code), .cal_done(cal_done), .cal_err(cal_err)
   );

   function automatic int exp_pick(int m);
      case (m)
         1:  return 0;
         2:  return 1;
         4:  return 2;
         8:  return 3;
         3:  return 0;
         6:  return 1;
         12: return 3;
         7:  return 1;
         14: return 2;
         15: return 1;
         default: return -1;
      endcase
   endfunction

   task automatic chk(bit good, string req, int act, int exp);
      total++;
      if (!good) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model, advanced on each rising edge from the input ports only
   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mw = 0; mi = 0; md = 0; mk = 0; mm = 0; mdone = 0; merr = 0;
      end else begin
         mdone = 0;
         if (ms == 0) begin
            if (cal_start) begin
               mk = md; md = 0; mi = 0; mm = 0; merr = 0;
               if (SETTLE > 0) begin ms = 1; mw = SETTLE - 1; end else ms = 2;
            end
         end else if (ms == 1) begin
            if (mw == 0) ms = 2; else mw--;
         end else if (ms == 2) begin
            if (rd_ack) begin
               if (rd_data == PAT) mm = mm | (1 << mi);
               if (mi == 3) ms = 3;
               else begin
                  mi++; md = mi;
                  if (SETTLE > 0) begin ms = 1; mw = SETTLE - 1; end
               end
            end
         end else begin
            if (exp_pick(mm) < 0) begin merr = 1; md = mk; end
            else md = exp_pick(mm);
            mdone = 1;
            ms = 0;
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en) begin
         chk(rd_req == (ms == 2), "R10", rd_req, ms == 2);
         chk(dly_code == md, "R2", dly_code, md);
         chk(cal_done == mdone, "R8", cal_done, mdone);
         chk(cal_err == merr, "R7", cal_err, merr);
         if (rd_req) chk(rd_addr == TADDR, "R2", rd_addr, TADDR);
      end
   end

   // read responder modelling the delay line: failing codes return a one-bit-off word
   always @(negedge clk) begin
      if (rd_ack) begin
         rd_ack = 1'b0;
      end else if (rd_req) begin
         if (lat_cnt >= lat_cfg) begin
            rd_ack  = 1'b1;
            rd_data = pass_map[dly_code] ? PAT : (PAT ^ 16'h0100);
            lat_cnt = 0;
         end else begin
            lat_cnt++;
         end
      end
   end

   task automatic run(logic [3:0] m, int lat, bit extra_start);
      int n = 0;
      int p;
      string tag;
      @(negedge clk);
      pass_map = m; lat_cfg = lat; lat_cnt = 0;
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      if (extra_start) begin
         repeat (4) @(negedge clk);
         cal_start = 1'b1;   // R9: must be ignored mid-sweep
         @(negedge clk);
         cal_start = 1'b0;
      end
      while (!cal_done && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(cal_done == 1'b1, "R8", cal_done, 1);
      p = exp_pick(int'(m));
      if (p < 0) begin
         chk(cal_err == 1'b1, "R7", cal_err, 1);
         chk(dly_code == last_good, "R7", dly_code, last_good);
      end else begin
         case ($countones(m))
            1: tag = "R4";
            2: tag = "R5";
            default: tag = "R6";
         endcase
         chk(cal_err == 1'b0, "R3", cal_err, 0);
         chk(dly_code == p, tag, dly_code, p);
         last_good = p;
      end
      @(negedge clk);
      chk(cal_done == 1'b0, "R8", cal_done, 0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(dly_code == 0, "R1", dly_code, 0);
      chk(cal_done == 0, "R1", cal_done, 0);
      chk(cal_err == 0, "R1", cal_err, 0);
      chk(rd_req == 0, "R1", rd_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1;
      run(4'b0001, 0, 0);
      run(4'b0010, 1, 0);
      run(4'b0100, 3, 0);
      run(4'b1000, 0, 0);
      run(4'b0011, 1, 0);
      run(4'b0110, 0, 0);
      run(4'b1100, 2, 0);
      run(4'b0111, 0, 1);
      run(4'b1110, 1, 0);
      run(4'b0101, 0, 0);   // gap after a passing sweep: code 2 restored
      run(4'b1111, 3, 1);
      run(4'b0000, 1, 0);
      run(4'b1001, 0, 0);
      run(4'b1011, 2, 0);
      run(4'b1101, 0, 1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R8 watchdog expired act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule